// File: doc/BRIEF.md
# Serial NOR Page-Program Sequencer

This block writes a byte buffer of any length into a serial NOR flash over a single-lane SPI master port. A request gives a 24-bit start address and a byte count. The data bytes then arrive on a valid/ready byte stream. The block splits the transfer into pieces that each stay inside one 256-byte page of the flash. The first piece runs only up to the next page boundary, and every later piece starts on a page boundary.

Each piece goes through the same three steps. The block sends a write-enable frame, then a program frame that carries the address and the data, then read-status frames until the device reports that it is idle. When the last piece is finished the block pulses `done_o`. If the device stays busy longer than the poll budget, the block pulses `err_o` and drops the rest of the transfer.

Top module: `spi_pp_seq`

## Requirements
- R1: Before every program frame the block sends a frame that holds only the single byte 0x06. Chip select goes high before that frame and again after it.
- R2: A program frame is the byte 0x02, then three address bytes sent most significant byte first (bits 23:16, 15:8, 7:0), then the data bytes of the piece in stream order.
- R3: A piece never crosses a 256-byte page boundary. Its length is the smaller of two values: the bytes still to write, and 256 minus the low 8 address bits. The next piece starts at the previous address plus the previous length.
- R4: After each program frame the block sends read-status frames. Each one is the byte 0x05 followed by one dummy byte 0x00, and chip select is high between frames. Only bit 0 of the returned status byte means busy, and no other bit has any effect. The next piece or `done_o` follows only after a status byte with bit 0 equal to 0.
- R5: The poll-cycle counter restarts at the start of each piece's polling. If it reaches TIMEOUT_CYC while bit 0 still reads 1, the block pulses `err_o` once, never pulses `done_o` for that request, starts no further frames and returns to idle.
- R6: A request with length 0 produces `done_o` in the cycle after it is accepted, and chip select stays high throughout.
- R7: The SPI port uses mode 0 with MSB first. SCLK is low whenever chip select is high. MOSI changes only on falling SCLK edges, and MISO is sampled on rising edges. One SCLK half-period lasts CLK_DIV clock cycles.
- R8: `req_ready_o` is high only while the block is idle, and chip select is high at that time. `done_o` and `err_o` are single-cycle pulses that are never high together.
- R9: The block takes exactly the requested number of data bytes, one per cycle in which `data_valid_i` and `data_ready_o` are both high. `data_ready_o` is high only inside a program frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| req_addr_i | input | 24 | Start byte address in the flash |
| req_len_i | input | LEN_W | Number of bytes to write |
| data_valid_i | input | 1 | Data byte valid |
| data_i | input | 8 | Data byte |
| data_ready_o | output | 1 | Data byte taken this cycle when valid is high |
| done_o | output | 1 | Transfer finished (pulse) |
| err_o | output | 1 | Busy-poll timeout, transfer aborted (pulse) |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
The bench aims at page-boundary splits: a start two bytes below a boundary, a full aligned page, an aligned page plus one byte, and a long run that starts in the middle of a page. A design that computes the piece length wrongly either sends a program frame that wraps inside the page or splits a piece that could have gone whole. The flash model returns a busy status of 0x01 and a ready status of 0xFE. A design that decodes the wrong status bit therefore never finishes, or starts the next piece too early. Other cases are a request with no polling delay, a request of length zero, and a device that never becomes ready. A design that mishandles the timeout either hangs, reports done, or keeps sending frames after the error.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned BUSY_BIT = 0;

  localparam logic [7:0] OP_WR_EN = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] DUMMY    = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_GAP_WE, ST_PP_CMD, ST_ADDR_HI, ST_ADDR_MID, ST_ADDR_LO,
    ST_DATA, ST_GAP_PP, ST_RDSR, ST_STAT, ST_GAP_POLL, ST_GAP_NEXT
  } pp_state_e;
endpackage

// File: rtl/spi_byte_eng.sv
// Mode-0 byte shifter: one byte per start, MSB first.
module spi_byte_eng #(
  parameter int unsigned CLK_DIV    = 2,
  parameter int unsigned SAMPLE_BIT = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rx_bit_o,
  output logic       sclk_o,
  output logic       mosi_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             busy_q, sclk_q, done_q;
  logic [7:0]       tx_q, rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          bit_q  <= '0;
          div_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= {tx_q[6:0], 1'b0};
          bit_q  <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rx_bit_o = rx_q[SAMPLE_BIT];
  assign sclk_o   = sclk_q;
  assign mosi_o   = busy_q & tx_q[7];
endmodule

// File: rtl/spi_pp_ctrl.sv
module spi_pp_ctrl
  import spi_pp_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned PAGE_LOG2   = 8,
  parameter int unsigned TIMEOUT_CYC = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  output logic              data_ready_o,
  input  logic              eng_done_i,
  input  logic              busy_bit_i,
  output logic              eng_start_o,
  output logic [7:0]        eng_tx_o,
  output logic              cs_no,
  output logic              done_o,
  output logic              err_o
);
  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1) << PAGE_LOG2;

  pp_state_e         state_q;
  logic              launched_q, done_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, chunk_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [LEN_W-1:0]  room, chunk_len;
  logic              byte_state, in_frame, polling;

  assign room      = PAGE_LEN - LEN_W'(addr_q[PAGE_LOG2-1:0]);
  assign chunk_len = (rem_q < room) ? rem_q : room;

  always_comb begin
    byte_state = 1'b0;
    eng_tx_o   = DUMMY;
    unique case (state_q)
      ST_WREN:     begin byte_state = 1'b1; eng_tx_o = OP_WR_EN; end
      ST_PP_CMD:   begin byte_state = 1'b1; eng_tx_o = OP_PROG; end
      ST_ADDR_HI:  begin byte_state = 1'b1; eng_tx_o = addr_q[23:16]; end
      ST_ADDR_MID: begin byte_state = 1'b1; eng_tx_o = addr_q[15:8]; end
      ST_ADDR_LO:  begin byte_state = 1'b1; eng_tx_o = addr_q[7:0]; end
      ST_DATA:     begin byte_state = 1'b1; eng_tx_o = data_i; end
      ST_RDSR:     begin byte_state = 1'b1; eng_tx_o = OP_STAT; end
      ST_STAT:     begin byte_state = 1'b1; eng_tx_o = DUMMY; end
      default:     ;
    endcase
  end

  assign in_frame     = byte_state;
  assign polling      = (state_q == ST_RDSR) || (state_q == ST_STAT) || (state_q == ST_GAP_POLL);
  assign data_ready_o = (state_q == ST_DATA) && !launched_q;
  assign eng_start_o  = byte_state && !launched_q && ((state_q != ST_DATA) || data_valid_i);
  assign req_ready_o  = (state_q == ST_IDLE);
  assign cs_no        = !in_frame;
  assign done_o       = done_q;
  assign err_o        = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      launched_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      addr_q     <= '0;
      rem_q      <= '0;
      chunk_q    <= '0;
      tmo_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (eng_start_o) launched_q <= 1'b1;
      if (eng_done_i)  launched_q <= 1'b0;
      if (polling && tmo_q != '1) tmo_q <= tmo_q + TMO_W'(1);

      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          rem_q  <= req_len_i;
          if (req_len_i == '0) done_q  <= 1'b1;
          else                 state_q <= ST_WREN;
        end
        ST_WREN:     if (eng_done_i) state_q <= ST_GAP_WE;
        ST_GAP_WE: begin
          chunk_q <= chunk_len;
          state_q <= ST_PP_CMD;
        end
        ST_PP_CMD:   if (eng_done_i) state_q <= ST_ADDR_HI;
        ST_ADDR_HI:  if (eng_done_i) state_q <= ST_ADDR_MID;
        ST_ADDR_MID: if (eng_done_i) state_q <= ST_ADDR_LO;
        ST_ADDR_LO:  if (eng_done_i) state_q <= ST_DATA;
        ST_DATA: if (eng_done_i) begin
          addr_q  <= addr_q + ADDR_W'(1);
          rem_q   <= rem_q - LEN_W'(1);
          chunk_q <= chunk_q - LEN_W'(1);
          if (chunk_q == LEN_W'(1)) state_q <= ST_GAP_PP;
        end
        ST_GAP_PP: begin
          tmo_q   <= '0;
          state_q <= ST_RDSR;
        end
        ST_RDSR: if (eng_done_i) state_q <= ST_STAT;
        ST_STAT: if (eng_done_i) begin
          if (busy_bit_i)          state_q <= ST_GAP_POLL;
          else if (rem_q == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else                 state_q <= ST_GAP_NEXT;
        end
        ST_GAP_POLL: begin
          if (tmo_q >= TMO_W'(TIMEOUT_CYC)) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b1;
          end else state_q <= ST_RDSR;
        end
        ST_GAP_NEXT: state_q <= ST_WREN;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pp_seq.sv
module spi_pp_seq
  import spi_pp_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 2,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned PAGE_LOG2   = 8,
  parameter int unsigned TIMEOUT_CYC = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  output logic              data_ready_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic       eng_start, eng_busy, eng_done, busy_bit;
  logic [7:0] eng_tx;

  spi_pp_ctrl #(
    .LEN_W(LEN_W), .PAGE_LOG2(PAGE_LOG2), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .data_valid_i, .data_i, .data_ready_o,
    .eng_done_i(eng_done), .busy_bit_i(busy_bit),
    .eng_start_o(eng_start), .eng_tx_o(eng_tx),
    .cs_no, .done_o, .err_o
  );

  spi_byte_eng #(.CLK_DIV(CLK_DIV), .SAMPLE_BIT(BUSY_BIT)) u_eng (
    .clk_i, .rst_ni,
    .start_i(eng_start), .tx_i(eng_tx), .miso_i,
    .busy_o(eng_busy), .done_o(eng_done), .rx_bit_o(busy_bit),
    .sclk_o, .mosi_o
  );

  // engine busy is implied by the controller's launch flag
  logic unused_busy;
  assign unused_busy = eng_busy;
endmodule

// File: rtl/spi_pp_seq_chk.sv
module spi_pp_seq_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [LEN_W-1:0] req_len_i,
  input logic             data_ready_o,
  input logic             done_o,
  input logic             err_o,
  input logic             sclk_o,
  input logic             cs_no,
  input logic             mosi_o
);
  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R7
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R7
  AST_ZERO_LEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i == '0) |=> done_o); // R6
  AST_IDLE_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_no); // R8
  AST_END_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DATA_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> !cs_no); // R9
endmodule

bind spi_pp_seq spi_pp_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_len_i,
  .data_ready_o, .done_o, .err_o, .sclk_o, .cs_no, .mosi_o
);

// File: tb/spi_pp_seq_test.sv
`timescale 1ns/1ps
module spi_pp_seq_test;
  localparam int LEN_W = 16;
  localparam int TMO   = 600;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [23:0] req_addr_i = '0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic data_valid_i, data_ready_o;
  logic [7:0] data_i;
  logic done_o, err_o, sclk_o, cs_no, mosi_o;
  logic miso_i;

  always #4 clk = ~clk;

  spi_pp_seq #(.CLK_DIV(2), .LEN_W(LEN_W), .PAGE_LOG2(8), .TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_len_i,
    .data_valid_i, .data_i, .data_ready_o, .done_o, .err_o,
    .sclk_o, .cs_no, .mosi_o, .miso_i
  );

  int tests = 0, fails = 0;
  task automatic chk(bit ok, string req, string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // scoreboard
  logic [7:0] exp_bytes[$];
  int         exp_len[$];
  logic [7:0] src_q[$];
  int  busy_polls = 0, busy_left = 0, poll_seen = 0, frame_cnt = 0;
  bit  ignore_poll = 0;

  task automatic push_frame1(logic [7:0] b);
    exp_len.push_back(1); exp_bytes.push_back(b);
  endtask

  task automatic drive_req(int addr, int len, int seed, int polls, bit tmo_case);
    int a = addr, rem = len, idx = 0;
    busy_polls = polls;
    while (rem > 0) begin
      int room = 256 - (a & 255);
      int c = (rem < room) ? rem : room;
      push_frame1(8'h06);
      exp_len.push_back(4 + c);
      exp_bytes.push_back(8'h02);
      exp_bytes.push_back(8'(a >> 16));
      exp_bytes.push_back(8'(a >> 8));
      exp_bytes.push_back(8'(a));
      for (int k = 0; k < c; k++) begin
        exp_bytes.push_back(8'(seed + idx));
        src_q.push_back(8'(seed + idx));
        idx++;
      end
      if (!tmo_case)
        for (int p = 0; p <= polls; p++) begin
          exp_len.push_back(2); exp_bytes.push_back(8'h05); exp_bytes.push_back(8'h00);
        end
      a += c; rem -= c;
    end
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 24'(addr); req_len_i = LEN_W'(len);
    chk(req_ready_o === 1'b1, "R8", $sformatf("ready before request act=%b exp=1", req_ready_o));
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  // data stream driver
  bit hs = 0;
  initial begin
    data_valid_i = 1'b0; data_i = '0;
    forever begin
      @(negedge clk);
      if (hs) void'(src_q.pop_front());
      data_valid_i = (src_q.size() > 0);
      data_i = (src_q.size() > 0) ? src_q[0] : 8'h00;
      hs = data_valid_i && data_ready_o;
    end
  end

  // flash model / monitor
  logic [7:0] fbuf[$];
  logic [7:0] sh = '0, cur_op = '0, stat_q = '0;
  int  bitcnt = 0;
  bit  in_frame = 0;

  task automatic end_frame();
    string tag;
    int n;
    bit ok;
    logic [7:0] e, act_b, exp_b;
    chk(bitcnt % 8 == 0, "R7", $sformatf("bits in frame act=%0d exp=multiple of 8", bitcnt));
    if (fbuf.size() == 0) return;
    if (fbuf[0] == 8'h05) begin
      if (busy_left > 0) busy_left--;
      if (ignore_poll) begin poll_seen++; return; end
    end
    if (fbuf[0] == 8'h02) busy_left = busy_polls;
    tag = (fbuf[0] == 8'h06) ? "R1" : (fbuf[0] == 8'h05) ? "R4" : "R2/R3/R7";
    if (exp_len.size() == 0) begin
      chk(0, tag, $sformatf("unexpected frame op=%02h act_len=%0d exp=none", fbuf[0], fbuf.size()));
      return;
    end
    n = exp_len.pop_front();
    ok = (n == fbuf.size());
    act_b = 0; exp_b = 0;
    for (int i = 0; i < n; i++) begin
      e = exp_bytes.pop_front();
      if (ok && fbuf[i] !== e) begin ok = 0; act_b = fbuf[i]; exp_b = e; end
    end
    chk(ok, tag, $sformatf("frame len act=%0d exp=%0d byte act=%02h exp=%02h",
                           fbuf.size(), n, act_b, exp_b));
  endtask

  initial begin
    forever begin
      @(posedge sclk_o or negedge cs_no or posedge cs_no);
      if (cs_no === 1'b0 && !in_frame) begin
        in_frame = 1; bitcnt = 0; fbuf.delete(); cur_op = 0;
        stat_q = (busy_left > 0) ? 8'h01 : 8'hFE;
      end else if (cs_no === 1'b0 && sclk_o === 1'b1) begin
        sh = {sh[6:0], mosi_o};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
          fbuf.push_back(sh);
          if (bitcnt == 8) cur_op = sh;
        end
      end else if (cs_no === 1'b1 && in_frame) begin
        in_frame = 0; frame_cnt++;
        end_frame();
      end
    end
  end

  initial begin
    miso_i = 1'b0;
    forever begin
      @(negedge sclk_o);
      if (cs_no === 1'b0 && cur_op == 8'h05 && bitcnt >= 8 && bitcnt < 16)
        miso_i = stat_q[15 - bitcnt];
    end
  end

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done_o) begin got_done = 1; break; end
      if (err_o)  begin got_err = 1; break; end
    end
  endtask

  task automatic run_ok(int addr, int len, int seed, int polls, string req);
    bit d, e;
    drive_req(addr, len, seed, polls, 0);
    wait_end(d, e);
    chk(d && !e, req, $sformatf("end of write @%06h len %0d act done=%b err=%b exp done=1 err=0", addr, len, d, e));
    repeat (4) @(negedge clk);
    chk(exp_len.size() == 0, req, $sformatf("frames missing act=%0d exp=0", exp_len.size()));
    chk(src_q.size() == 0, "R9", $sformatf("data bytes left act=%0d exp=0", src_q.size()));
  endtask

  initial begin
    bit d, e;
    int fc;
    repeat (3) @(negedge clk);
    chk(cs_no === 1'b1 && sclk_o === 1'b0, "R7", $sformatf("reset SPI act cs=%b sclk=%b exp 1/0", cs_no, sclk_o));
    chk(done_o === 1'b0 && err_o === 1'b0 && data_ready_o === 1'b0, "R8",
        $sformatf("reset outputs act done=%b err=%b drdy=%b exp 0", done_o, err_o, data_ready_o));
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o === 1'b1, "R8", $sformatf("idle ready act=%b exp=1", req_ready_o));

    // R6 zero length
    fc = frame_cnt;
    req_valid_i = 1'b1; req_addr_i = 24'h000123; req_len_i = '0;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(done_o === 1'b1, "R6", $sformatf("zero-length done act=%b exp=1", done_o));
    repeat (50) @(negedge clk);
    chk(frame_cnt == fc, "R6", $sformatf("zero-length frames act=%0d exp=0", frame_cnt - fc));

    run_ok(24'h012300, 4, 8'h10, 3, "R1/R2/R4");
    run_ok(24'h0000FE, 5, 8'h40, 0, "R3");
    run_ok(24'h0A0010, 300, 8'h80, 1, "R3");
    run_ok(24'h000100, 256, 8'h00, 2, "R3");
    run_ok(24'h3FFF00, 257, 8'hC3, 0, "R3");

    // R5 device stuck busy
    ignore_poll = 1; poll_seen = 0;
    drive_req(24'h005000, 3, 8'h22, 100000, 1);
    wait_end(d, e);
    chk(e && !d, "R5", $sformatf("timeout act done=%b err=%b exp done=0 err=1", d, e));
    @(negedge clk);
    chk(err_o === 1'b0, "R5", $sformatf("err pulse width act=%b exp=0", err_o));
    chk(poll_seen >= 2, "R5", $sformatf("poll frames act=%0d exp>=2", poll_seen));
    fc = frame_cnt;
    repeat (300) @(negedge clk);
    chk(frame_cnt == fc && cs_no === 1'b1, "R5", $sformatf("frames after error act=%0d exp=0", frame_cnt - fc));
    chk(exp_len.size() == 0, "R1/R2", $sformatf("frames before timeout missing act=%0d exp=0", exp_len.size()));
    ignore_poll = 0; busy_left = 0;

    run_ok(24'h0001F0, 20, 8'h55, 2, "R5");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule